// File: doc/BRIEF.md
# Angle Sensor Serial Reader with Safety-Word Check

This block is the bus master for a magnetic angle sensor that talks over a half-duplex synchronous serial link with a single bidirectional data line. When the host asks for a reading, the block lowers chip select, clocks out a 16-bit read command MSB first, releases the data line, and clocks in two 16-bit words: first the register contents, then a safety word. All three words travel inside one chip-select window. The serial clock is derived from the system clock by a parameterised divider.

The safety word carries three active-low fault flags and an 8-bit CRC. The block checks the flags in a fixed priority order. Only when none of them is raised does it recompute the CRC over the command and data bytes and compare it with the received one. The result is a small error code, a 15-bit angle and a saturating error counter. If a frame ends with a flag fault (any fault other than a CRC mismatch), the block reads the sensor's status register once more, within the same request, so that the sensor's latched fault is cleared before the result is reported.

Top module: `ssr_angle_reader`

## Requirements
- R1: An angle read sends the command word 0x8021: bit 15 = 1 (read, sent first), bits 14:11 = 0 (lock code), bit 10 = 0 (current values, not the update buffer), bits 9:4 = angle register address 2, bits 3:0 = 1 (one data word, which also requests the safety word). A status-clear read sends 0x8001 (address 0).
- R2: While chip select (`csn_o`, active low) is low, exactly 16 serial clock rising edges occur with the data-line driver enabled and 32 with it released. The serial clock idles low whenever chip select is high, and the driver is never enabled outside chip select.
- R3: The driver enable drops at the falling serial clock edge that ends the 16th command bit. The first read bit is sampled on the rising edge exactly three divider half-periods later, which gives one full idle serial clock period for turnaround. Read bits are sampled on rising edges, data word first, then safety word, each MSB first.
- R4: Safety bits 14 (system), 13 (interface) and 12 (invalid angle) are active low. They are ranked in that order, and the highest-ranked raised flag alone gives the error code.
- R5: With all three flags clear, a CRC-8 is computed over command-high, command-low, data-high and data-low, MSB first, with polynomial 0x1D and start value 0xFF. The result is inverted. If it differs from safety bits 7:0, the error code is 4.
- R6: Error codes are 0 none, 1 system, 2 interface, 3 invalid angle, 4 CRC. The code appears with a one-cycle `done_o` pulse and is held until the next result.
- R7: On error code 0, `angle_o` takes data bits 14:0. On any other code it keeps its previous value.
- R8: After error codes 1, 2 or 3, and only then, one extra read of status register 0 is made before `done_o` is raised.
- R9: `err_cnt_o` increments once for each result with a non-zero code and saturates at its maximum.
- R10: After reset, chip select is high, the serial clock and driver enable are low, and all results are zero. A request made while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an angle read (accepted when idle) |
| sdio_i | input | 1 | Data line value as seen at the pad |
| sclk_o | output | 1 | Serial clock, idles low |
| csn_o | output | 1 | Chip select, active low |
| sdio_o | output | 1 | Data line value driven during the command |
| sdio_oe_o | output | 1 | Data line driver enable |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_code_o | output | 3 | Result code (R6 encoding) |
| angle_o | output | 15 | Last valid angle |
| err_cnt_o | output | CNT_W | Saturating count of failed results |

## Verification
The bench builds the block with a divider half-period of 2 system clocks and a 3-bit error counter. The short divider keeps each frame near 200 cycles, so many frames fit in one run. The narrow counter lets a few consecutive faulty frames drive it to its ceiling, which puts the saturation case within reach. A behavioural sensor on the pins builds the safety word from injected flag and CRC faults. It also counts the clear reads, the command words and the edges in each frame.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

   typedef enum logic [2:0] {
      ERR_NONE = 3'd0,
      ERR_SYS  = 3'd1,
      ERR_IFC  = 3'd2,
      ERR_ANG  = 3'd3,
      ERR_CRC  = 3'd4
   } err_e;

   typedef enum logic [2:0] {F_IDLE, F_CMD, F_TURN, F_RD, F_END} fstate_e;

   typedef enum logic [1:0] {T_IDLE, T_ANGLE, T_CLEAR} tstate_e;

   // CRC over a 32-bit stream, MSB first, inverted at the end
   function automatic logic [7:0] crc8_stream(input logic [31:0] bits,
                                              input logic [7:0]  poly,
                                              input logic [7:0]  seed);
      logic [7:0] c;
      logic       fb;
      c = seed;
      for (int i = 31; i >= 0; i--) begin
         fb = c[7] ^ bits[i];
         c  = {c[6:0], 1'b0};
         if (fb) c = c ^ poly;
      end
      return ~c;
   endfunction

endpackage

// File: rtl/ssr_clkdiv.sv
module ssr_clkdiv #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = $clog2(HALF_DIV);
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == LAST);
endmodule

// File: rtl/ssr_frame.sv
module ssr_frame import ssr_pkg::*; #(
   parameter int WORD_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  start,
   input  logic [WORD_W-1:0]     cmd,
   input  logic                  sdio_i,
   output logic                  busy,
   output logic                  done,
   output logic [2*WORD_W-1:0]   rx_word,
   output logic                  sclk,
   output logic                  csn,
   output logic                  sdo,
   output logic                  oe
);
   localparam int BW = $clog2(2 * WORD_W);
   localparam logic [BW-1:0] LAST_CMD = BW'(WORD_W - 1);
   localparam logic [BW-1:0] LAST_RD  = BW'(2 * WORD_W - 1);

   fstate_e             st;
   logic [WORD_W-1:0]   sh;
   logic [BW-1:0]       bitc;
   logic                tflag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         sh      <= '0;
         rx_word <= '0;
         bitc    <= '0;
         tflag   <= 1'b0;
         sclk    <= 1'b0;
         csn     <= 1'b1;
         oe      <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            F_IDLE: if (start) begin
               st   <= F_CMD;
               sh   <= cmd;
               oe   <= 1'b1;
               csn  <= 1'b0;
               bitc <= '0;
            end
            F_CMD: if (tick) begin
               if (!sclk) sclk <= 1'b1;
               else begin
                  sclk <= 1'b0;
                  if (bitc == LAST_CMD) begin
                     oe    <= 1'b0;
                     tflag <= 1'b0;
                     st    <= F_TURN;
                  end else begin
                     bitc <= bitc + 1'b1;
                     sh   <= {sh[WORD_W-2:0], 1'b0};
                  end
               end
            end
            F_TURN: if (tick) begin
               if (tflag) begin
                  st   <= F_RD;
                  bitc <= '0;
               end else tflag <= 1'b1;
            end
            F_RD: if (tick) begin
               if (!sclk) begin
                  sclk    <= 1'b1;
                  rx_word <= {rx_word[2*WORD_W-2:0], sdio_i};
               end else begin
                  sclk <= 1'b0;
                  if (bitc == LAST_RD) st <= F_END;
                  else                 bitc <= bitc + 1'b1;
               end
            end
            F_END: if (tick) begin
               csn  <= 1'b1;
               done <= 1'b1;
               st   <= F_IDLE;
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   assign busy = (st != F_IDLE);
   assign sdo  = oe & sh[WORD_W-1];
endmodule

// File: rtl/ssr_safety_chk.sv
module ssr_safety_chk import ssr_pkg::*; #(
   parameter logic [7:0] CRC_POLY = 8'h1D,
   parameter logic [7:0] CRC_SEED = 8'hFF
) (
   input  logic [15:0] cmd,
   input  logic [15:0] data,
   input  logic [2:0]  flags_n,   // {system, interface, angle}, active low
   input  logic [7:0]  crc_rx,
   output err_e        code
);
   logic [7:0] crc_calc;

   assign crc_calc = crc8_stream({cmd, data}, CRC_POLY, CRC_SEED);

   always_comb begin
      if (!flags_n[2])              code = ERR_SYS;
      else if (!flags_n[1])         code = ERR_IFC;
      else if (!flags_n[0])         code = ERR_ANG;
      else if (crc_calc != crc_rx)  code = ERR_CRC;
      else                          code = ERR_NONE;
   end
endmodule

// File: rtl/ssr_angle_reader.sv
module ssr_angle_reader import ssr_pkg::*; #(
   parameter int         HALF_DIV   = 4,
   parameter int         CNT_W      = 16,
   parameter int         ANGLE_REG  = 2,
   parameter int         STATUS_REG = 0,
   parameter bit         AUTO_CLEAR = 1'b1,
   parameter logic [7:0] CRC_POLY   = 8'h1D,
   parameter logic [7:0] CRC_SEED   = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             sdio_i,
   output logic             sclk_o,
   output logic             csn_o,
   output logic             sdio_o,
   output logic             sdio_oe_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [2:0]       err_code_o,
   output logic [14:0]      angle_o,
   output logic [CNT_W-1:0] err_cnt_o
);
   localparam int WORD_W = 16;
   localparam int ANGLE_W = 15;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [WORD_W-1:0] CMD_ANGLE  = {1'b1, 4'b0000, 1'b0, 6'(ANGLE_REG), 4'd1};
   localparam logic [WORD_W-1:0] CMD_STATUS = {1'b1, 4'b0000, 1'b0, 6'(STATUS_REG), 4'd1};

   // elaboration-time parameter checks
   if (HALF_DIV < 2) begin : g_bad_div
      $error("HALF_DIV must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (ANGLE_REG < 0 || ANGLE_REG > 63 || STATUS_REG < 0 || STATUS_REG > 63) begin : g_bad_addr
      $error("register addresses must fit in 6 bits");
   end

   logic                  tick, f_busy, f_done, f_start;
   logic [2*WORD_W-1:0]   rx;
   logic [WORD_W-1:0]     cmd_q;
   err_e                  chk_code, pend_q, err_q, code_fin;
   tstate_e               st;
   logic                  need_clr, fin;
   logic [ANGLE_W-1:0]    angle_q;
   logic [CNT_W-1:0]      cnt_q;
   logic                  done_q;
   logic                  unused_sw;

   ssr_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .en(f_busy), .tick(tick)
   );

   ssr_frame #(.WORD_W(WORD_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(f_start), .cmd(cmd_q),
      .sdio_i(sdio_i), .busy(f_busy), .done(f_done), .rx_word(rx),
      .sclk(sclk_o), .csn(csn_o), .sdo(sdio_o), .oe(sdio_oe_o)
   );

   ssr_safety_chk #(.CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)) u_safe (
      .cmd(cmd_q), .data(rx[31:16]), .flags_n(rx[14:12]), .crc_rx(rx[7:0]),
      .code(chk_code)
   );

   // reset indication and sensor number are not used by this block
   assign unused_sw = ^{rx[15], rx[11:8]};

   if (AUTO_CLEAR) begin : g_clear
      assign need_clr = (chk_code != ERR_NONE) && (chk_code != ERR_CRC);
   end else begin : g_noclear
      assign need_clr = 1'b0;
   end

   always_comb begin
      code_fin = (st == T_ANGLE) ? chk_code : pend_q;
      fin      = f_done && ((st == T_CLEAR) || (st == T_ANGLE && !need_clr));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= T_IDLE;
         f_start <= 1'b0;
         cmd_q   <= '0;
         pend_q  <= ERR_NONE;
         err_q   <= ERR_NONE;
         angle_q <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         f_start <= 1'b0;
         done_q  <= 1'b0;
         case (st)
            T_IDLE: if (req_i) begin
               cmd_q   <= CMD_ANGLE;
               f_start <= 1'b1;
               st      <= T_ANGLE;
            end
            T_ANGLE: if (f_done) begin
               pend_q <= chk_code;
               if (chk_code == ERR_NONE) angle_q <= rx[31:16+WORD_W-ANGLE_W-1+1-1+1-1];
               if (need_clr) begin
                  cmd_q   <= CMD_STATUS;
                  f_start <= 1'b1;
                  st      <= T_CLEAR;
               end
            end
            T_CLEAR: ;
            default: st <= T_IDLE;
         endcase
         if (fin) begin
            err_q  <= code_fin;
            done_q <= 1'b1;
            st     <= T_IDLE;
            if (code_fin != ERR_NONE && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy_o     = (st != T_IDLE);
   assign done_o     = done_q;
   assign err_code_o = err_q;
   assign angle_o    = angle_q;
   assign err_cnt_o  = cnt_q;
endmodule

// File: rtl/ssr_angle_reader_chk.sv
module ssr_angle_reader_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             csn_o,
   input logic             sclk_o,
   input logic             sdio_oe_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [2:0]       err_code_o,
   input logic [14:0]      angle_o,
   input logic [CNT_W-1:0] err_cnt_o
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   p_oe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe_o |-> !csn_o);
   p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      csn_o |-> !sclk_o);
   p_turn_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdio_oe_o) |-> (!sclk_o && !csn_o));
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_code_o <= 3'd4);
   p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(err_code_o));
   p_angle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(angle_o));
   p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((err_code_o == 3'd0) ? (err_cnt_o == $past(err_cnt_o))
                  : ((err_cnt_o == $past(err_cnt_o) + 1'b1) || ($past(err_cnt_o) == MAXV))));
   p_cnt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(err_cnt_o));
   p_idle_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> csn_o);
endmodule

bind ssr_angle_reader ssr_angle_reader_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .csn_o(csn_o), .sclk_o(sclk_o),
   .sdio_oe_o(sdio_oe_o), .busy_o(busy_o), .done_o(done_o),
   .err_code_o(err_code_o), .angle_o(angle_o), .err_cnt_o(err_cnt_o)
);

// File: tb/ssr_angle_reader_tb_top.sv
`timescale 1ns/1ps
module ssr_angle_reader_tb_top;
   localparam int  HALF = 2;
   localparam int  CW   = 3;
   localparam int  CMAX = 7;
   localparam real TCLK = 5.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic sdio_i;
   logic sclk_o, csn_o, sdio_o, sdio_oe_o, busy_o, done_o;
   logic [2:0]    err_code_o;
   logic [14:0]   angle_o;
   logic [CW-1:0] err_cnt_o;

   always #2.5 clk = ~clk;

   ssr_angle_reader #(.HALF_DIV(HALF), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .sdio_i(sdio_i),
      .sclk_o(sclk_o), .csn_o(csn_o), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o),
      .busy_o(busy_o), .done_o(done_o), .err_code_o(err_code_o),
      .angle_o(angle_o), .err_cnt_o(err_cnt_o)
   );

   function automatic logic [7:0] tb_crc(input logic [15:0] c, input logic [15:0] d);
      logic [7:0] b [4];
      logic [7:0] r;
      b[0] = c[15:8]; b[1] = c[7:0]; b[2] = d[15:8]; b[3] = d[7:0];
      r = 8'hFF;
      for (int i = 0; i < 4; i++) begin
         r = r ^ b[i];
         for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
      end
      return ~r;
   endfunction

   // ---------------- sensor model ----------------
   logic [15:0] m_cmd = '0;
   logic [15:0] m_data = '0;
   bit m_sys = 1, m_ifc = 1, m_ang = 1, m_crcbad = 0;
   int m_rc = 32;
   logic [15:0] r_data, r_safe;
   logic [31:0] m_resp;
   int tot_cmd = 0, tot_rd = 0, snap_cmd = 0, snap_rd = 0;
   int n_ang = 0, n_clr = 0, m_chk = 0, m_bad = 0;
   realtime t_oe = 0.0;

   always_comb begin
      if (m_cmd[9:4] == 6'd2) begin
         r_data = m_data;
         r_safe = {1'b0, m_sys, m_ifc, m_ang, 4'h3,
                   tb_crc(m_cmd, m_data) ^ (m_crcbad ? 8'h5A : 8'h00)};
      end else begin
         r_data = 16'h0000;
         r_safe = {1'b0, 3'b111, 4'h3, tb_crc(m_cmd, 16'h0000)};
      end
      m_resp = {r_data, r_safe};
   end

   assign sdio_i = (m_rc >= 32) ? 1'b0 : m_resp[31 - m_rc];

   always @(negedge sdio_oe_o) t_oe = $realtime;

   always @(posedge sclk_o) begin
      if (sdio_oe_o) begin
         m_cmd = {m_cmd[14:0], sdio_o};
         m_rc  = 0;
         tot_cmd++;
      end else begin
         if (m_rc == 0) begin
            m_chk++;
            if (($realtime - t_oe) > 3*HALF*TCLK + 0.01 || ($realtime - t_oe) < 3*HALF*TCLK - 0.01) begin
               m_bad++;
               $display("FAIL R3 turnaround: actual %0t expected %0t", $realtime - t_oe, 3*HALF*TCLK);
            end
         end
         m_rc++;
         tot_rd++;
      end
   end

   always @(posedge csn_o) begin
      if (rst_n) begin
         m_chk++;
         if (tot_cmd - snap_cmd != 16 || tot_rd - snap_rd != 32) begin
            m_bad++;
            $display("FAIL R2 edges per frame: actual %0d/%0d expected 16/32",
                     tot_cmd - snap_cmd, tot_rd - snap_rd);
         end
         snap_cmd = tot_cmd;
         snap_rd  = tot_rd;
         if (m_cmd == 16'h8021) n_ang++;
         else if (m_cmd == 16'h8001) n_clr++;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [2:0]  code;
      logic [14:0] ang;
      int          cnt;
      int          nclr;
      int          nang;
      string       tag;
   } item_t;

   item_t q[$];
   int n_chk = 0, n_err = 0;
   int e_cnt = 0, e_nclr = 0, e_nang = 0;
   logic [14:0] e_ang = '0;
   bit prev_done = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   always @(negedge clk) begin : mon
      item_t it;
      if (rst_n) begin
         if (prev_done) chk(!done_o, "R6", "done width", longint'(done_o), 0);
         if (done_o) begin
            if (q.size() == 0) chk(1'b0, "R10", "unexpected done", 1, 0);
            else begin
               it = q.pop_front();
               chk(err_code_o == it.code, it.tag, "error code", longint'(err_code_o), longint'(it.code));
               chk(angle_o == it.ang, "R7", "angle", longint'(angle_o), longint'(it.ang));
               chk(int'(err_cnt_o) == it.cnt, "R9", "error count", longint'(err_cnt_o), longint'(it.cnt));
               chk(n_clr == it.nclr, "R8", "clear reads", longint'(n_clr), longint'(it.nclr));
               chk(n_ang == it.nang, "R1", "angle commands", longint'(n_ang), longint'(it.nang));
            end
         end
         prev_done = done_o;
      end
   end

   task automatic pulse_req();
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
   endtask

   task automatic wait_empty();
      int n = 0;
      while (q.size() != 0 && n < 4000) begin
         @(negedge clk); n++;
      end
      if (n >= 4000) begin
         chk(1'b0, "R6", "watchdog, done missing", 0, 1);
         q.delete();
      end
   endtask

   task automatic do_read(input logic [15:0] d, input bit s, input bit i,
                          input bit a, input bit c, input string tg);
      item_t it;
      logic [2:0] code;
      m_data = d; m_sys = s; m_ifc = i; m_ang = a; m_crcbad = c;
      code = !s ? 3'd1 : !i ? 3'd2 : !a ? 3'd3 : c ? 3'd4 : 3'd0;
      e_nang++;
      if (code inside {3'd1, 3'd2, 3'd3}) e_nclr++;
      if (code == 3'd0) e_ang = d[14:0];
      if (code != 3'd0 && e_cnt < CMAX) e_cnt++;
      it.code = code; it.ang = e_ang; it.cnt = e_cnt;
      it.nclr = e_nclr; it.nang = e_nang; it.tag = tg;
      q.push_back(it);
      pulse_req();
      wait_empty();
      repeat (4) @(negedge clk);
      chk(err_code_o == code, "R6", "code held", longint'(err_code_o), longint'(code));
   endtask

   bit finished = 0;

   initial begin
      repeat (3) @(negedge clk);
      chk(csn_o == 1'b1, "R10", "reset csn", longint'(csn_o), 1);
      chk(sclk_o == 1'b0 && sdio_oe_o == 1'b0, "R10", "reset sclk/oe",
          longint'({sclk_o, sdio_oe_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R10", "idle flags", longint'({busy_o, done_o}), 0);
      chk(err_code_o == 3'd0 && angle_o == 15'd0 && err_cnt_o == '0, "R10", "reset results",
          longint'({err_code_o, angle_o, err_cnt_o}), 0);

      do_read(16'h9234, 1, 1, 1, 0, "R1");
      do_read(16'h7FFF, 1, 1, 1, 0, "R7");
      do_read(16'h0ABC, 0, 0, 1, 1, "R4");   // system outranks interface
      do_read(16'h0ABC, 1, 0, 0, 0, "R4");   // interface outranks angle
      do_read(16'h0ABC, 1, 1, 0, 0, "R8");
      do_read(16'h1111, 1, 1, 1, 1, "R5");   // crc error: no clear read
      do_read(16'h0000, 1, 1, 1, 0, "R5");
      for (int k = 0; k < 4; k++) do_read(16'h2222, 1, 1, 1, 1, "R9");
      do_read(16'h4321, 1, 1, 1, 0, "R9");

      // R10: second request while busy is ignored
      begin
         item_t it;
         m_data = 16'h0155; m_sys = 1; m_ifc = 1; m_ang = 1; m_crcbad = 0;
         e_nang++; e_ang = 15'h0155;
         it.code = 3'd0; it.ang = e_ang; it.cnt = e_cnt;
         it.nclr = e_nclr; it.nang = e_nang; it.tag = "R10";
         q.push_back(it);
         pulse_req();
         repeat (30) @(negedge clk);
         chk(busy_o == 1'b1, "R10", "busy during frame", longint'(busy_o), 1);
         pulse_req();
         wait_empty();
         repeat (600) @(negedge clk);
         chk(n_ang == e_nang, "R10", "frames after ignored request", longint'(n_ang), longint'(e_nang));
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_bad);
      $finish;
   end

   initial begin
      #(200000 * TCLK);
      if (!finished) begin
         chk(1'b0, "R6", "global watchdog", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_bad);
         $finish;
      end
   end
endmodule